// File: doc/BRIEF.md
# Throughput-Limited Memory Target with Deferred Retry

This block is a single-ported memory target. A requester offers one request per cycle on a request channel. The request carries a command, a size code, an address, write data, a flag that asks for a response and an inhibit flag. The target answers in the same cycle through `req_ready`: either it takes the request or it refuses it. It does not stall the requester with plain backpressure. It uses a one-shot refuse-then-retry exchange instead. A refused requester waits for a single-cycle `retry` pulse and then offers its request again.

A read or write that is taken makes the target busy for the access size in bytes times `CPB` cycles. This caps the short-term data rate. Any other command is served without that hold-off. The storage is accessed in the cycle the request is taken. When a response is asked for, it is placed in an in-order queue and comes out `LAT` cycles later. It stays on the response channel until `rsp_ready` is high. An inhibited request is taken and dropped: it causes no access, no response and no hold-off.

Top module: `bwmem_target`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `retry` are 0. Every storage word reads as zero.
- R2: A non-inhibited read (cmd 0) or write (cmd 1) of 2^size bytes that is taken drives `req_ready` low for exactly bytes×CPB cycles after the cycle in which it is taken. When no retry is owed, `req_ready` is high again in the next cycle.
- R3: A non-inhibited request that is refused puts the target in debt for a retry. `retry` then pulses high for exactly one cycle, in the first cycle in which the target is neither busy nor holding a full response queue. Without a refusal, `retry` never rises.
- R4: While a retry is owed, including the cycle of the `retry` pulse, every non-inhibited request is refused. The retried request is taken in the cycle after the pulse.
- R5: A command other than read or write (cmd 2 or 3) that is taken leaves `req_ready` high in the next cycle. No hold-off starts.
- R6: A request with `req_inhibit` high is always taken, even while the target is busy or a retry is owed. It changes no storage byte and produces no response.
- R7: A response first appears on `rsp_valid` exactly LAT cycles after its request was taken, provided no earlier response is still waiting. While `rsp_ready` is low, `rsp_valid`, `rsp_data` and `rsp_kind` hold their values.
- R8: Responses leave in the order their requests were taken. A read returns the full 64-bit word at address bits [AW-1:3], as it stood when the read was taken. A write updates only the byte lanes from address bits [2:0] up to bits [2:0] + bytes − 1, each from the same lane of `req_wdata`.
- R9: A request taken with `req_need_rsp` low produces no response.
- R10: While the response queue holds QDEPTH undelivered entries, non-inhibited requests are refused. The retry follows the cycle in which an entry leaves.
- R11: `rsp_kind` repeats the command of the request. Responses to writes and to other commands carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is offered this cycle |
| req_ready | output | 1 | High when the offered request is taken this cycle |
| req_cmd | input | 2 | 0 read, 1 write, 2 and 3 other commands |
| req_size | input | 2 | Access size code; bytes = 2^size |
| req_addr | input | AW | Byte address; AW = log2(WORDS) + 3 |
| req_wdata | input | 64 | Write data on lane-aligned byte positions |
| req_need_rsp | input | 1 | The request wants a response |
| req_inhibit | input | 1 | Another agent supplies the data; take and drop |
| retry | output | 1 | One-cycle pulse: a refused request may be offered again |
| rsp_valid | output | 1 | A response is presented |
| rsp_ready | input | 1 | Requester takes the presented response |
| rsp_data | output | 64 | Read data, zero for other responses |
| rsp_kind | output | 2 | Command of the request being answered |

## Verification
The hardest state to reach is a retry that is owed while the target is not busy at all, because the queue is full. To get there, the response channel is stalled and four non-throttled commands that want responses are taken back to back. A fifth request is then offered and refused. After that, the response channel is released while the bench counts cycles to the `retry` pulse. A second hard case is an inhibited write issued in the middle of a long hold-off. It must be taken at once. A later read of its address must show that it left no trace.

// File: rtl/bwmem_pkg.sv
package bwmem_pkg;

    typedef enum logic [1:0] {
        CMD_READ   = 2'd0,
        CMD_WRITE  = 2'd1,
        CMD_MISC_A = 2'd2,
        CMD_MISC_B = 2'd3
    } cmd_e;

    // Bytes moved by an access of size code sz.
    function automatic logic [3:0] size_to_bytes(input logic [1:0] sz);
        return 4'd1 << sz;
    endfunction

    // Byte lanes touched by an access of size sz starting at lane off.
    function automatic logic [7:0] lane_mask(input logic [1:0] sz, input logic [2:0] off);
        logic [15:0] m;
        m = {8'h00, (8'hFF >> (4'd8 - size_to_bytes(sz)))} << off;
        return m[7:0];
    endfunction

    function automatic logic is_rw(input logic [1:0] c);
        return (c == CMD_READ) || (c == CMD_WRITE);
    endfunction

endpackage

// File: rtl/bwmem_throttle.sv
module bwmem_throttle
    import bwmem_pkg::*;
#(
    parameter int CPB = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_cmd,
    input  logic [1:0] req_size,
    input  logic       req_inhibit,
    input  logic       q_full,
    output logic       req_ready,
    output logic       take,
    output logic       retry
);

    localparam int CW = $clog2(8 * CPB + 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pending;
    } th_state_t;

    th_state_t st_q, st_d;
    logic      blocked;

    always_comb begin
        blocked   = (st_q.cnt != '0) | q_full;
        retry     = st_q.pending & ~blocked;
        req_ready = req_inhibit | (~blocked & ~st_q.pending);
        take      = req_valid & req_ready & ~req_inhibit;

        st_d = st_q;
        // Debt for a retry: set on refusal, paid when the block frees up.
        if (retry) begin
            st_d.pending = 1'b0;
        end else if (req_valid & ~req_ready) begin
            st_d.pending = 1'b1;
        end
        // Hold-off: bytes times cycles-per-byte; zero keeps the block idle.
        if (take & is_rw(req_cmd)) begin
            st_d.cnt = CW'(int'(size_to_bytes(req_size)) * CPB);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bwmem_store.sv
module bwmem_store #(
    parameter int WORDS = 64,
    parameter int IW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_be,
    input  logic [63:0]   wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [63:0]   rd_data
);

    logic [63:0] mem_q [WORDS];
    logic [63:0] mem_d [WORDS];
    logic [63:0] old_word;
    logic [63:0] merged;

    assign old_word = mem_q[wr_idx];

    for (genvar b = 0; b < 8; b++) begin : g_lane
        assign merged[8*b +: 8] = wr_be[b] ? wr_data[8*b +: 8] : old_word[8*b +: 8];
    end

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_idx] = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/bwmem_rspq.sv
module bwmem_rspq #(
    parameter int DEPTH = 4,
    parameter int LAT   = 30
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push,
    input  logic [63:0] push_data,
    input  logic [1:0]  push_kind,
    input  logic        pop_ready,
    output logic        full,
    output logic        head_valid,
    output logic [63:0] head_data,
    output logic [1:0]  head_kind
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int WW = (LAT > 1) ? $clog2(LAT) : 1;

    typedef struct packed {
        logic [63:0]   data;
        logic [1:0]    kind;
        logic [WW-1:0] wait_c;
    } ent_t;

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [PW:0]   cnt;
    } ptr_t;

    ent_t ent_q [DEPTH];
    ent_t ent_d [DEPTH];
    ptr_t ptr_q, ptr_d;
    ent_t head;
    logic pop;

    always_comb begin
        head       = ent_q[ptr_q.rp];
        head_valid = (ptr_q.cnt != '0) && (head.wait_c == '0);
        head_data  = head.data;
        head_kind  = head.kind;
        full       = (ptr_q.cnt == (PW+1)'(DEPTH));
        pop        = head_valid & pop_ready;

        // Every slot ages in step; a newly written slot starts at LAT-1.
        for (int e = 0; e < DEPTH; e++) begin
            ent_d[e] = ent_q[e];
            if (ent_q[e].wait_c != '0) begin
                ent_d[e].wait_c = ent_q[e].wait_c - 1'b1;
            end
            if (push && (ptr_q.wp == PW'(e))) begin
                ent_d[e].data   = push_data;
                ent_d[e].kind   = push_kind;
                ent_d[e].wait_c = WW'(LAT - 1);
            end
        end

        ptr_d = ptr_q;
        if (push) begin
            ptr_d.wp = (ptr_q.wp == PW'(DEPTH - 1)) ? '0 : ptr_q.wp + 1'b1;
        end
        if (pop) begin
            ptr_d.rp = (ptr_q.rp == PW'(DEPTH - 1)) ? '0 : ptr_q.rp + 1'b1;
        end
        ptr_d.cnt = ptr_q.cnt + (PW+1)'(push) - (PW+1)'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            for (int e = 0; e < DEPTH; e++) begin
                ent_q[e] <= '0;
            end
        end else begin
            ptr_q <= ptr_d;
            ent_q <= ent_d;
        end
    end

endmodule

// File: rtl/bwmem_target.sv
module bwmem_target
    import bwmem_pkg::*;
#(
    parameter int  WORDS  = 64,
    parameter int  LAT    = 30,
    parameter int  CPB    = 1,
    parameter int  QDEPTH = 4,
    localparam int IW     = $clog2(WORDS),
    localparam int AW     = IW + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_cmd,
    input  logic [1:0]    req_size,
    input  logic [AW-1:0] req_addr,
    input  logic [63:0]   req_wdata,
    input  logic          req_need_rsp,
    input  logic          req_inhibit,
    output logic          retry,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [63:0]   rsp_data,
    output logic [1:0]    rsp_kind
);

    logic          take;
    logic          q_full;
    logic [IW-1:0] word_idx;
    logic [7:0]    be;
    logic [63:0]   rd_word;
    logic          wr_en;
    logic          push;
    logic [63:0]   push_data;

    assign word_idx  = req_addr[AW-1:3];
    assign be        = lane_mask(req_size, req_addr[2:0]);
    assign wr_en     = take & (req_cmd == CMD_WRITE);
    assign push      = take & req_need_rsp;
    assign push_data = (req_cmd == CMD_READ) ? rd_word : '0;

    bwmem_throttle #(
        .CPB (CPB)
    ) u_throttle (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_cmd     (req_cmd),
        .req_size    (req_size),
        .req_inhibit (req_inhibit),
        .q_full      (q_full),
        .req_ready   (req_ready),
        .take        (take),
        .retry       (retry)
    );

    bwmem_store #(
        .WORDS (WORDS),
        .IW    (IW)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (word_idx),
        .wr_be   (be),
        .wr_data (req_wdata),
        .rd_idx  (word_idx),
        .rd_data (rd_word)
    );

    bwmem_rspq #(
        .DEPTH (QDEPTH),
        .LAT   (LAT)
    ) u_rspq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_data  (push_data),
        .push_kind  (req_cmd),
        .pop_ready  (rsp_ready),
        .full       (q_full),
        .head_valid (rsp_valid),
        .head_data  (rsp_data),
        .head_kind  (rsp_kind)
    );

endmodule

// File: rtl/bwmem_target_chk.sv
module bwmem_target_chk #(
    parameter int CPB = 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [1:0]  req_cmd,
    input logic        req_inhibit,
    input logic        retry,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [63:0] rsp_data,
    input logic [1:0]  rsp_kind
);

    // R2: a taken read or write closes the door in the following cycle
    a_r2_holdoff_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_inhibit && (req_cmd[1] == 1'b0) && (CPB != 0))
        |=> (!req_ready || req_inhibit));

    // R3: retry lasts a single cycle
    a_r3_retry_single: assert property (@(posedge clk) disable iff (!rst_n)
        retry |=> !retry);

    // R4: the retry cycle itself still refuses ordinary requests
    a_r4_refuse_on_retry: assert property (@(posedge clk) disable iff (!rst_n)
        retry |-> (!req_ready || req_inhibit));

    // R6: inhibited requests are always taken
    a_r6_inhibit_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_inhibit) |-> req_ready);

    // R7: a stalled response holds still
    a_r7_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_kind)));

endmodule

bind bwmem_target bwmem_target_chk #(.CPB(CPB)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_cmd     (req_cmd),
    .req_inhibit (req_inhibit),
    .retry       (retry),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_data    (rsp_data),
    .rsp_kind    (rsp_kind)
);

// File: tb/bwmem_target_bench.sv
module bwmem_target_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LAT    = 6;
    localparam int CPB    = 2;
    localparam int QDEPTH = 4;
    localparam int WORDS  = 16;
    localparam int AW     = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_cmd = 2'd0;
    logic [1:0]    req_size = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0]   req_wdata = '0;
    logic          req_need_rsp = 1'b0;
    logic          req_inhibit = 1'b0;
    logic          retry;
    logic          rsp_valid;
    logic          rsp_ready = 1'b1;
    logic [63:0]   rsp_data;
    logic [1:0]    rsp_kind;

    always #(CLK_PERIOD/2) clk = ~clk;

    bwmem_target #(
        .WORDS (WORDS), .LAT (LAT), .CPB (CPB), .QDEPTH (QDEPTH)
    ) u_bwmem_target (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_cmd (req_cmd), .req_size (req_size), .req_addr (req_addr),
        .req_wdata (req_wdata), .req_need_rsp (req_need_rsp),
        .req_inhibit (req_inhibit), .retry (retry),
        .rsp_valid (rsp_valid), .rsp_ready (rsp_ready),
        .rsp_data (rsp_data), .rsp_kind (rsp_kind)
    );

    typedef struct {
        logic [63:0] data;
        logic [1:0]  kind;
        int          due;
    } exp_t;

    exp_t        sb[$];
    logic [63:0] shadow [WORDS];
    int          cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Monitor: compare each delivered response with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && rsp_valid && rsp_ready) begin
            if (sb.size() == 0) begin
                chk(1'b0, $sformatf("R9 unexpected response: actual kind=%0d data=%h expected none",
                                    rsp_kind, rsp_data));
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(rsp_data == e.data, $sformatf("R8 data: actual=%h expected=%h", rsp_data, e.data));
                chk(rsp_kind == e.kind, $sformatf("R11 kind: actual=%0d expected=%0d", rsp_kind, e.kind));
                chk(cyc >= e.due, $sformatf("R7 early response: actual cycle=%0d expected>=%0d", cyc, e.due));
            end
        end
    end

    // Driver: offer a request, sample the answer, record what must come back.
    task automatic drive(input logic [1:0] cmd, input logic [1:0] sz, input logic [AW-1:0] addr,
                         input logic [63:0] wd, input bit need, input bit inh,
                         output bit acc, output int ac);
        @(posedge clk); #1;
        req_valid = 1'b1; req_cmd = cmd; req_size = sz; req_addr = addr;
        req_wdata = wd; req_need_rsp = need; req_inhibit = inh;
        @(negedge clk);
        acc = req_ready;
        ac  = cyc;
        if (acc && !inh) begin
            logic [63:0] w;
            int          off;
            int          nb;
            exp_t        e;
            w   = shadow[addr[AW-1:3]];
            off = int'(addr[2:0]);
            nb  = 1 << sz;
            e.kind = cmd;
            e.data = (cmd == 2'd0) ? w : 64'd0;
            e.due  = cyc + LAT;
            if (cmd == 2'd1) begin
                for (int b = 0; b < 8; b++) begin
                    if (b >= off && b < off + nb) w[8*b +: 8] = wd[8*b +: 8];
                end
                shadow[addr[AW-1:3]] = w;
            end
            if (need) sb.push_back(e);
        end
    endtask

    task automatic release_bus();
        @(posedge clk); #1;
        req_valid = 1'b0; req_inhibit = 1'b0;
    endtask

    task automatic count_closed(output int n);
        n = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            chk(!retry, $sformatf("R3 spurious retry: actual=1 expected=0 at cycle %0d", cyc));
            if (req_ready) break;
            n++;
        end
    endtask

    task automatic drain();
        for (int k = 0; k < 300 && sb.size() != 0; k++) @(negedge clk);
        chk(sb.size() == 0, $sformatf("R7 responses missing: actual pending=%0d expected=0", sb.size()));
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        chk(1'b0, "watchdog (all): actual=timeout expected=completion");
        report();
        $finish;
    end

    initial begin
        bit acc;
        int ac;
        int n;
        int seen;
        logic [63:0] held;

        for (int i = 0; i < WORDS; i++) shadow[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state and zeroed storage
        @(negedge clk);
        chk(req_ready == 1'b1, $sformatf("R1 req_ready: actual=%0d expected=1", req_ready));
        chk(rsp_valid == 1'b0, $sformatf("R1 rsp_valid: actual=%0d expected=0", rsp_valid));
        chk(retry == 1'b0, $sformatf("R1 retry: actual=%0d expected=0", retry));
        drive(2'd0, 2'd3, 7'h18, '0, 1'b1, 1'b0, acc, ac);
        release_bus();
        count_closed(n);
        chk(n == 8 * CPB, $sformatf("R1 hold-off of read: actual=%0d expected=%0d", n, 8 * CPB));

        // R2 + R8: full word write, then a 2-byte lane write, then a read
        drive(2'd1, 2'd3, 7'h08, 64'h1122_3344_5566_7788, 1'b1, 1'b0, acc, ac);
        chk(acc, "R2 write taken: actual=0 expected=1");
        release_bus();
        count_closed(n);
        chk(n == 16, $sformatf("R2 8-byte hold-off: actual=%0d expected=16", n));
        drive(2'd1, 2'd1, 7'h0A, 64'hAAAA_BBBB_CCCC_DDDD, 1'b1, 1'b0, acc, ac);
        release_bus();
        count_closed(n);
        chk(n == 4, $sformatf("R2 2-byte hold-off: actual=%0d expected=4", n));
        drive(2'd1, 2'd0, 7'h0F, 64'h5A00_0000_0000_0000, 1'b0, 1'b0, acc, ac);
        release_bus();
        count_closed(n);
        chk(n == 2, $sformatf("R2 1-byte hold-off: actual=%0d expected=2", n));
        drive(2'd0, 2'd2, 7'h0C, '0, 1'b1, 1'b0, acc, ac);
        release_bus();
        count_closed(n);
        drain();

        // R3 + R4: refusal during hold-off, then exactly one retry
        drive(2'd1, 2'd0, 7'h20, 64'h0000_0000_0000_0042, 1'b1, 1'b0, acc, ac);
        drive(2'd0, 2'd3, 7'h20, '0, 1'b1, 1'b0, acc, n);
        chk(!acc, "R3 request during hold-off refused: actual=taken expected=refused");
        release_bus();
        seen = -1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (retry) begin
                seen = cyc;
                chk(!req_ready, "R4 req_ready in retry cycle: actual=1 expected=0");
                break;
            end
        end
        chk(seen == ac + 2 * CPB * 0 + 3, $sformatf("R3 retry cycle: actual=%0d expected=%0d", seen, ac + 3));
        drive(2'd0, 2'd3, 7'h20, '0, 1'b1, 1'b0, acc, ac);
        chk(acc, "R4 retried request taken: actual=refused expected=taken");
        release_bus();
        count_closed(n);
        drain();

        // R5: other commands open no hold-off
        drive(2'd2, 2'd3, 7'h00, '0, 1'b1, 1'b0, acc, ac);
        drive(2'd3, 2'd3, 7'h00, '0, 1'b1, 1'b0, acc, ac);
        chk(acc, "R5 back-to-back other command: actual=refused expected=taken");
        release_bus();
        @(negedge clk);
        chk(req_ready, "R5 req_ready after other command: actual=0 expected=1");
        drain();

        // R6: inhibited write mid hold-off is taken and leaves no trace
        drive(2'd1, 2'd3, 7'h30, 64'hCAFE_F00D_0BAD_BEEF, 1'b0, 1'b0, acc, ac);
        release_bus();
        count_closed(n);
        drive(2'd1, 2'd3, 7'h08, 64'h0, 1'b0, 1'b0, acc, ac);
        drive(2'd1, 2'd3, 7'h30, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, acc, ac);
        chk(acc, "R6 inhibited request while busy: actual=refused expected=taken");
        release_bus();
        for (int k = 0; k < LAT + 2; k++) begin
            @(negedge clk);
            chk(!rsp_valid, "R6 response from inhibited request: actual=1 expected=0");
        end
        count_closed(n);
        drive(2'd0, 2'd3, 7'h30, '0, 1'b1, 1'b0, acc, ac);
        release_bus();
        count_closed(n);
        drain();

        // R9: no response when none is asked for
        drive(2'd0, 2'd3, 7'h30, '0, 1'b0, 1'b0, acc, ac);
        release_bus();
        for (int k = 0; k < LAT + 20; k++) begin
            @(negedge clk);
            chk(!rsp_valid, "R9 response without request for one: actual=1 expected=0");
        end

        // R7: exact latency and hold under stall
        @(posedge clk); #1 rsp_ready = 1'b0;
        drive(2'd0, 2'd3, 7'h08, '0, 1'b1, 1'b0, acc, ac);
        release_bus();
        seen = -1;
        for (int k = 0; k < 60; k++) begin
            if (rsp_valid) begin seen = cyc; break; end
            @(negedge clk);
        end
        chk(seen == ac + LAT, $sformatf("R7 first valid cycle: actual=%0d expected=%0d", seen, ac + LAT));
        held = rsp_data;
        repeat (3) @(negedge clk);
        chk(rsp_valid && rsp_data == held,
            $sformatf("R7 stalled response: actual valid=%0d data=%h expected valid=1 data=%h",
                      rsp_valid, rsp_data, held));
        @(posedge clk); #1 rsp_ready = 1'b1;
        count_closed(n);
        drain();

        // R10: full queue refuses, retry follows the first delivery
        @(posedge clk); #1 rsp_ready = 1'b0;
        for (int i = 0; i < QDEPTH; i++) begin
            drive(2'd2, 2'd0, 7'h00, '0, 1'b1, 1'b0, acc, ac);
            chk(acc, $sformatf("R10 fill entry %0d: actual=refused expected=taken", i));
        end
        drive(2'd2, 2'd0, 7'h00, '0, 1'b1, 1'b0, acc, ac);
        chk(!acc, "R10 request with full queue: actual=taken expected=refused");
        release_bus();
        for (int k = 0; k < LAT + 4; k++) begin
            @(negedge clk);
            chk(!retry && !req_ready,
                $sformatf("R10 while full: actual retry=%0d ready=%0d expected 0/0", retry, req_ready));
        end
        @(posedge clk); #1 rsp_ready = 1'b1;
        seen = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (retry) begin seen = 1; break; end
        end
        chk(seen == 1, "R10 retry after slot freed: actual=none expected=pulse");
        drive(2'd2, 2'd0, 7'h00, '0, 1'b1, 1'b0, acc, ac);
        chk(acc, "R10 retried request: actual=refused expected=taken");
        release_bus();
        drain();

        report();
        $finish;
    end

endmodule